// File: doc/BRIEF.md
# Tremolo Amplitude Modulator

This block puts a tremolo on a stream of 16-bit signed audio samples. Each sample is scaled by a slowly moving gain taken from a table holding one full period of a raised sine. The table has no quarter-wave folding. A 10-bit address register picks the table entry. On every accepted sample, the register advances by an 8-bit speed value, modulo the table size, so the speed sets the carrier frequency. With the default 1024 entries, a speed `s` gives a carrier of `s/1024` cycles per sample.

Samples arrive on a clock-enable pulse at the audio rate, about 22 kHz, while the clock runs much faster. The scaled sample is held in a register, so the output changes only on an enabled edge and lags the input by one sample. The gain is unsigned and never negative, so the output keeps the sign of its input. Decoding the speed setting and blending the result with the dry signal are left to surrounding logic.

Top module: `tremolo_modulator`

## Requirements
- R1: While `rst_ni` is low, `smp_o` is 0 and the phase address is 0. The first enabled sample after reset is therefore scaled by table entry 0.
- R2: On each clock edge with `smp_en_i` high, the phase address becomes (address + `speed_i`) mod 1024. The sample on that edge is scaled by the entry at the address from before the update.
- R3: On edges with `smp_en_i` low, `smp_o` and the phase address hold, whatever `smp_i` and `speed_i` do.
- R4: After an enabled edge, `smp_o` equals floor(`smp_i` × g / 65536), where g is the selected gain. This is bits 31..16 of the signed product.
- R5: Gain entry k, for k = 0..1023, is round(32767.5 × (1 + sin(2πk/1024))), clipped to 65535. The table covers one whole period.
- R6: With `speed_i` = 0 the address does not move, so every sample gets the same gain.
- R7: The output never inverts or grows: for an input x ≥ 0, 0 ≤ out ≤ x; for an input x < 0, x ≤ out ≤ 0.
- R8: The address wraps modulo 1024 when the sum overflows, including at `speed_i` = 255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| smp_en_i | input | 1 | Sample-rate clock enable |
| smp_i | input | 16 | Signed input sample |
| speed_i | input | 8 | Unsigned address step per sample |
| smp_o | output | 16 | Signed modulated sample, registered |

## Verification
Several properties are checked on every cycle:
- the output and the phase address hold while the enable is low;
- the address holds on enabled edges when the speed is zero;
- the output is zero during reset;
- the output stays within the bounds and sign of the previous input.

Only the bench scenarios can show that:
- the correct table entry is chosen after a given history of speeds;
- the address wraps correctly;
- the gain values follow the raised sine over the whole period.

The bench shows these by tracking the address and the product arithmetically across full-table sweeps.

// File: rtl/trem_pkg.sv
package trem_pkg;
  parameter int unsigned SAMPLE_W = 16;
  parameter int unsigned SPEED_W  = 8;
  parameter int unsigned ADDR_W   = 10;
  parameter int unsigned GAIN_W   = 16;

  localparam real PI_C = 3.14159265358979;

  // raised sine, 0.5 + 0.5*sin, scaled to full unsigned range
  function automatic logic [GAIN_W-1:0] gain_of(int k, int n);
    real ph;
    real v;
    longint r;
    longint top;
    top = (longint'(1) << GAIN_W) - 1;
    ph = 2.0 * PI_C * real'(k) / real'(n);
    v  = (real'(top) / 2.0) * (1.0 + $sin(ph));
    r  = longint'($floor(v + 0.5));
    if (r > top) r = top;
    if (r < 0) r = 0;
    return GAIN_W'(r);
  endfunction
endpackage

// File: rtl/trem_phase_acc.sv
module trem_phase_acc #(
  parameter int unsigned SPEED_W = trem_pkg::SPEED_W,
  parameter int unsigned ADDR_W  = trem_pkg::ADDR_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               step_i,
  input  logic [SPEED_W-1:0] speed_i,
  output logic [ADDR_W-1:0]  addr_o
);
  localparam int unsigned SUM_W = ((SPEED_W > ADDR_W) ? SPEED_W : ADDR_W) + 1;

  logic [ADDR_W-1:0] addr_q;
  logic [SUM_W-1:0]  sum_w;

  // modulo table size by truncation
  assign sum_w = SUM_W'(addr_q) + SUM_W'(speed_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     addr_q <= '0;
    else if (step_i) addr_q <= sum_w[ADDR_W-1:0];
  end

  assign addr_o = addr_q;
endmodule

// File: rtl/trem_sine_rom.sv
module trem_sine_rom #(
  parameter int unsigned ADDR_W = trem_pkg::ADDR_W,
  parameter int unsigned GAIN_W = trem_pkg::GAIN_W
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [GAIN_W-1:0] gain_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [GAIN_W-1:0] table_w [DEPTH];

  for (genvar k = 0; k < DEPTH; k++) begin : g_ent
    localparam logic [GAIN_W-1:0] ENT = trem_pkg::gain_of(k, DEPTH);
    assign table_w[k] = ENT;
  end

  assign gain_o = table_w[addr_i];
endmodule

// File: rtl/trem_scale_mul.sv
module trem_scale_mul #(
  parameter int unsigned SAMPLE_W = trem_pkg::SAMPLE_W,
  parameter int unsigned GAIN_W   = trem_pkg::GAIN_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                en_i,
  input  logic [SAMPLE_W-1:0] smp_i,
  input  logic [GAIN_W-1:0]   gain_i,
  output logic [SAMPLE_W-1:0] smp_o
);
  localparam int unsigned PROD_W = SAMPLE_W + GAIN_W + 1;

  logic signed [SAMPLE_W-1:0] smp_s;
  logic signed [GAIN_W:0]     gain_s;
  logic signed [PROD_W-1:0]   prod_w;
  logic [SAMPLE_W-1:0]        out_q;

  assign smp_s  = signed'(smp_i);
  assign gain_s = signed'({1'b0, gain_i});
  assign prod_w = PROD_W'(smp_s) * PROD_W'(gain_s);

  // upper bits = floor(x*g / 2^GAIN_W); gain < 2^GAIN_W so result fits
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   out_q <= '0;
    else if (en_i) out_q <= prod_w[GAIN_W +: SAMPLE_W];
  end

  assign smp_o = out_q;
endmodule

// File: rtl/tremolo_modulator.sv
module tremolo_modulator #(
  parameter int unsigned SAMPLE_W = trem_pkg::SAMPLE_W,
  parameter int unsigned SPEED_W  = trem_pkg::SPEED_W,
  parameter int unsigned ADDR_W   = trem_pkg::ADDR_W,
  parameter int unsigned GAIN_W   = trem_pkg::GAIN_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                smp_en_i,
  input  logic [SAMPLE_W-1:0] smp_i,
  input  logic [SPEED_W-1:0]  speed_i,
  output logic [SAMPLE_W-1:0] smp_o
);
  logic [ADDR_W-1:0] addr_w;
  logic [GAIN_W-1:0] gain_w;

  trem_phase_acc #(.SPEED_W(SPEED_W), .ADDR_W(ADDR_W)) u_acc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .step_i  (smp_en_i),
    .speed_i (speed_i),
    .addr_o  (addr_w)
  );

  trem_sine_rom #(.ADDR_W(ADDR_W), .GAIN_W(GAIN_W)) u_rom (
    .addr_i (addr_w),
    .gain_o (gain_w)
  );

  trem_scale_mul #(.SAMPLE_W(SAMPLE_W), .GAIN_W(GAIN_W)) u_mul (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (smp_en_i),
    .smp_i  (smp_i),
    .gain_i (gain_w),
    .smp_o  (smp_o)
  );
endmodule

// File: rtl/tremolo_modulator_chk.sv
module tremolo_modulator_chk #(
  parameter int unsigned SAMPLE_W = trem_pkg::SAMPLE_W,
  parameter int unsigned SPEED_W  = trem_pkg::SPEED_W,
  parameter int unsigned ADDR_W   = trem_pkg::ADDR_W
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                smp_en_i,
  input logic [SAMPLE_W-1:0] smp_i,
  input logic [SPEED_W-1:0]  speed_i,
  input logic [SAMPLE_W-1:0] smp_o,
  input logic [ADDR_W-1:0]   addr_i
);
  // R1: output cleared while reset held
  p_reset_out_r1: assert property (@(posedge clk_i) !rst_ni |-> smp_o == '0)
    else $error("R1 output not zero in reset");

  // R3: output holds without enable
  p_hold_out_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !smp_en_i |=> $stable(smp_o))
    else $error("R3 output moved without enable");

  // R3: address holds without enable
  p_hold_addr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !smp_en_i |=> $stable(addr_i))
    else $error("R3 address moved without enable");

  // R6: zero speed leaves address in place
  p_zero_speed_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_en_i && speed_i == '0 |=> $stable(addr_i))
    else $error("R6 address moved at zero speed");

  // R7: non-negative input gives 0 <= out <= input
  p_pos_bound_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_en_i && !smp_i[SAMPLE_W-1] |=>
      !smp_o[SAMPLE_W-1] && $signed(smp_o) <= $signed($past(smp_i)))
    else $error("R7 positive bound broken");

  // R7: negative input gives input <= out <= 0
  p_neg_bound_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_en_i && smp_i[SAMPLE_W-1] |=>
      $signed(smp_o) <= 0 && $signed(smp_o) >= $signed($past(smp_i)))
    else $error("R7 negative bound broken");
endmodule

bind tremolo_modulator tremolo_modulator_chk #(
  .SAMPLE_W(SAMPLE_W), .SPEED_W(SPEED_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .smp_en_i (smp_en_i),
  .smp_i    (smp_i),
  .speed_i  (speed_i),
  .smp_o    (smp_o),
  .addr_i   (addr_w)
);

// File: tb/tremolo_modulator_test.sv
`timescale 1ns/1ps
module tremolo_modulator_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        smp_en_i = 1'b0;
  logic [15:0] smp_i = '0;
  logic [7:0]  speed_i = '0;
  logic [15:0] smp_o;

  int errors = 0;
  int checks = 0;
  int model_addr = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  tremolo_modulator uut (
    .clk_i    (clk),
    .rst_ni   (rst_ni),
    .smp_en_i (smp_en_i),
    .smp_i    (smp_i),
    .speed_i  (speed_i),
    .smp_o    (smp_o)
  );

  function automatic int gain_model(int k);
    real v;
    int r;
    v = 32767.5 * (1.0 + $sin(2.0 * 3.14159265358979 * real'(k) / 1024.0));
    r = int'($floor(v + 0.5));
    if (r > 65535) r = 65535;
    return r;
  endfunction

  function automatic int expect_out(int x, int g);
    longint p;
    p = longint'(x) * longint'(g);
    return int'(p >>> 16);
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one enabled sample; compare registered output after the edge
  task automatic push(string req, int x, int spd);
    int g;
    int e;
    @(negedge clk);
    smp_i = 16'(x);
    speed_i = 8'(spd);
    smp_en_i = 1'b1;
    g = gain_model(model_addr);
    e = expect_out(x, g);
    model_addr = (model_addr + spd) % 1024;
    @(negedge clk);
    smp_en_i = 1'b0;
    check(req, int'($signed(smp_o)), e);
    @(negedge clk);
  endtask

  initial begin
    int held;
    #1;
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 reset output", int'($signed(smp_o)), 0);
    rst_ni = 1'b1;

    // R1: first sample uses entry 0 (gain 32768)
    push("R1 first sample", 1000, 0);
    // R6: zero speed, constant gain
    for (int i = 0; i < 40; i++) push("R6 zero speed", i * 1637 - 32768, 0);

    // R5 R2: full-table sweep at speed 1 with full-scale input
    for (int i = 0; i < 1024; i++) push("R5 table sweep", 32767, 1);
    // R4: negative full-scale at speed 3
    for (int i = 0; i < 400; i++) push("R4 negative scaling", -32768, 3);

    // R8: wrap at maximum speed
    for (int i = 0; i < 300; i++) push("R8 wrap speed 255", (i % 2) ? 20000 : -20001, 255);

    // R3: disabled edges ignore inputs
    held = int'($signed(smp_o));
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      smp_i = 16'(i * 4000 - 16000);
      speed_i = 8'(i * 31 + 1);
      @(negedge clk);
      check("R3 hold output", int'($signed(smp_o)), held);
    end
    push("R3 address kept", 30000, 7);

    // R2: changing speed each sample
    for (int s = 0; s < 256; s++) push("R2 speed sweep", (s * 257) - 32768, s);

    // R7: extreme and small values
    for (int i = 0; i < 200; i++) begin
      push("R7 polarity", -1, 5);
      push("R7 polarity", 1, 5);
      push("R7 polarity", -32768, 2);
      push("R7 polarity", 32767, 2);
    end

    // R1: reset mid-run
    @(negedge clk);
    rst_ni = 1'b0;
    @(negedge clk);
    check("R1 reset mid-run", int'($signed(smp_o)), 0);
    rst_ni = 1'b1;
    model_addr = 0;
    push("R1 restart from entry 0", -12345, 9);
    push("R1 restart second", 23456, 9);

    if (!done) begin
      done = 1'b1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #800000;
    if (!done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule